// File: doc/BRIEF.md
# Write-Back Slot Scheduler

This block decides, at issue time, when each result of a single-issue pipeline will be written back. Instructions issue in order, but their results return out of order because the execution units have different fixed latencies. Each instruction presents its operand and destination register numbers together with an operation class. A small class table turns the class into a slot index: the unit latency plus the crossbar transit cycles. The block then books a write-back slot by placing the destination number into a shifting queue at that index. One position per cycle, the entries move towards the bottom. The bottom entry drives the register-file write enable and the register number for its lane.

A busy bit for each register marks results that are still in flight. An instruction stalls when any register it reads or writes is still in flight, when its booked slot is already taken, or when the divider is occupied. Divides take longer than the queue is deep. A down-counter in front of the queue holds a divide's register number and drops it into the top slot once the extra cycles have passed.

Top module: `wb_sched`

## Requirements
- R1: After reset, both write enables are low and every register is ready, so a valid request whose registers are all free does not stall.
- R2: Class codes 0 (logic) and 1 (byte add) have a unit latency of 1, code 2 (add) has 2 and code 3 (multiply) has 6. Codes 6 and 7 behave as code 0. An instruction accepted in cycle c drives lane 0 with its first destination in cycle c + unit latency + XBAR_CYC.
- R3: A request stalls while source A, source B, the first destination or (for code 5) the second destination names a register whose write is still pending. It is accepted in the cycle after that register's write enable.
- R4: Register 0 is never marked pending and is never written. A request that names it issues without delay, and a write to it books no slot.
- R5: A request whose lane-0 slot is already booked for the same write-back cycle stalls until the slot is free. For example, a logic op that directly follows an add stalls one cycle.
- R6: Code 5 (paired add, unit latency 2) writes its first destination on lane 0 and its second on lane 1 in the same cycle. It needs that slot free on both lanes.
- R7: Code 4 (divide) writes lane 0 exactly DIV_LAT cycles after acceptance. Only one divide is held at a time, so a second divide stalls until the counter is idle. It is accepted DIV_LAT - DEPTH + 1 cycles after the first.
- R8: In the cycle a held divide enters the top of the queue, a request that targets the top slot (multiply) stalls for one cycle.
- R9: The stall output is low whenever no request is valid, and a stalled request books nothing and produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request present |
| iss_cls | input | 3 | Operation class code |
| iss_src_a | input | RW | First source register |
| iss_src_b | input | RW | Second source register |
| iss_dst0 | input | RW | First destination register |
| iss_dst1 | input | RW | Second destination (code 5 only) |
| iss_stall | output | 1 | Request cannot issue this cycle |
| wb0_en | output | 1 | Lane 0 register-file write enable |
| wb0_reg | output | RW | Lane 0 register number |
| wb1_en | output | 1 | Lane 1 register-file write enable |
| wb1_reg | output | RW | Lane 1 register number |

## Verification
The bench builds the block with 64 registers, a two-cycle crossbar and DIV_LAT set to 14. This gives a hold count of only 6 cycles. With that setting, the second-divide stall and the cycle in which a divide drops into the top slot fall within a few cycles of issue. The queue keeps its full depth of 8, so a multiply still books the top slot and can collide with the entering divide. Back-to-back class sequences and long-before-short orderings then expose slot collisions on both lanes.

// File: rtl/wb_sched_pkg.sv
package wb_sched_pkg;

    typedef enum logic [2:0] {
        CLS_LOGIC    = 3'd0,
        CLS_ADD_B    = 3'd1,
        CLS_ADD      = 3'd2,
        CLS_MUL      = 3'd3,
        CLS_DIV      = 3'd4,
        CLS_ADD_PAIR = 3'd5,
        CLS_RSV6     = 3'd6,
        CLS_RSV7     = 3'd7
    } op_cls_e;

    localparam int LAT_LOGIC = 1;
    localparam int LAT_ADD_B = 1;
    localparam int LAT_ADD   = 2;
    localparam int LAT_MUL   = 6;
    localparam int LAT_MAX   = LAT_MUL;
    localparam int SLOT_W    = 4;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              pair;
        logic              is_div;
    } iss_info_t;

    // Unit latency per class; the divide is timed by its own counter.
    function automatic int unit_lat(op_cls_e c);
        case (c)
            CLS_ADD_B:    return LAT_ADD_B;
            CLS_ADD:      return LAT_ADD;
            CLS_ADD_PAIR: return LAT_ADD;
            CLS_MUL:      return LAT_MUL;
            CLS_DIV:      return 0;
            default:      return LAT_LOGIC;
        endcase
    endfunction

endpackage

// File: rtl/wb_lat_table.sv
module wb_lat_table
    import wb_sched_pkg::*;
#(
    parameter int XBAR_CYC = 2
) (
    input  logic [2:0] cls,
    output iss_info_t  info
);
    op_cls_e c;
    assign c = op_cls_e'(cls);

    always_comb begin
        info.slot   = SLOT_W'(unit_lat(c) + XBAR_CYC);
        info.pair   = (c == CLS_ADD_PAIR);
        info.is_div = (c == CLS_DIV);
    end
endmodule

// File: rtl/wb_scoreboard.sv
module wb_scoreboard #(
    parameter int NREG = 64,
    parameter int RW   = $clog2(NREG),
    parameter int NW   = 2,
    parameter int NCHK = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NW-1:0]            set_en,
    input  logic [NW-1:0][RW-1:0]    set_reg,
    input  logic [NW-1:0]            clr_en,
    input  logic [NW-1:0][RW-1:0]    clr_reg,
    input  logic [NCHK-1:0]          chk_en,
    input  logic [NCHK-1:0][RW-1:0]  chk_reg,
    output logic                     hazard
);
    logic [NREG-1:0] pend_q;
    logic [NREG-1:0] set_m;
    logic [NREG-1:0] clr_m;

    always_comb begin
        set_m = '0;
        clr_m = '0;
        for (int w = 0; w < NW; w++) begin
            if (set_en[w]) set_m[set_reg[w]] = 1'b1;
            if (clr_en[w]) clr_m[clr_reg[w]] = 1'b1;
        end
        set_m[0] = 1'b0;   // register 0 is constant
    end

    always_comb begin
        hazard = 1'b0;
        for (int k = 0; k < NCHK; k++) begin
            if (chk_en[k] && pend_q[chk_reg[k]]) hazard = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_m) | set_m;
    end
endmodule

// File: rtl/wb_div_delay.sv
module wb_div_delay #(
    parameter int HOLD = 12,
    parameter int RW   = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [RW-1:0] start_reg,
    output logic          busy,
    output logic          inj,
    output logic [RW-1:0] inj_reg
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_q;
    logic [RW-1:0] reg_q;

    assign busy    = (cnt_q != '0);
    assign inj     = (cnt_q == CW'(1)) && (reg_q != '0);
    assign inj_reg = reg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            reg_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(HOLD);
            reg_q <= start_reg;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wb_slot_queue.sv
module wb_slot_queue #(
    parameter int DEPTH = 8,
    parameter int RW    = 6,
    parameter int LANES = 2,
    parameter int IW    = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [IW-1:0]            tgt,
    input  logic [LANES-1:0]         put,
    input  logic [LANES-1:0][RW-1:0] put_reg,
    input  logic                     inj,
    input  logic [RW-1:0]            inj_reg,
    output logic [LANES-1:0]         tgt_busy,
    output logic [LANES-1:0]         out_vld,
    output logic [LANES-1:0][RW-1:0] out_reg
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DEPTH-1:0]         vq;
        logic [DEPTH-1:0][RW-1:0] rq;
        logic                     top_v;
        logic [RW-1:0]            top_r;
        logic [DEPTH:0]           v;
        logic [DEPTH:0][RW-1:0]   r;
        logic                     hit;

        if (l == 0) begin : g_feed
            assign top_v = inj;
            assign top_r = inj_reg;
        end else begin : g_nofeed
            assign top_v = 1'b0;
            assign top_r = '0;
        end

        assign v = {top_v, vq};
        assign r = {top_r, rq};

        // Index DEPTH is the entry that slides into the top slot this edge.
        always_comb begin
            hit = 1'b1;
            for (int i = 1; i <= DEPTH; i++) begin
                if (int'(tgt) == i) hit = v[i];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                vq <= '0;
                rq <= '0;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (put[l] && int'(tgt) == i + 1) begin
                        vq[i] <= 1'b1;
                        rq[i] <= put_reg[l];
                    end else begin
                        vq[i] <= v[i+1];
                        rq[i] <= r[i+1];
                    end
                end
            end
        end

        assign tgt_busy[l] = hit;
        assign out_vld[l]  = vq[0];
        assign out_reg[l]  = rq[0];
    end
endmodule

// File: rtl/wb_sched.sv
module wb_sched
    import wb_sched_pkg::*;
#(
    parameter int NREG     = 64,
    parameter int XBAR_CYC = 2,
    parameter int DIV_LAT  = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    iss_valid,
    input  logic [2:0]              iss_cls,
    input  logic [$clog2(NREG)-1:0] iss_src_a,
    input  logic [$clog2(NREG)-1:0] iss_src_b,
    input  logic [$clog2(NREG)-1:0] iss_dst0,
    input  logic [$clog2(NREG)-1:0] iss_dst1,
    output logic                    iss_stall,
    output logic                    wb0_en,
    output logic [$clog2(NREG)-1:0] wb0_reg,
    output logic                    wb1_en,
    output logic [$clog2(NREG)-1:0] wb1_reg
);
    localparam int RW    = $clog2(NREG);
    localparam int DEPTH = LAT_MAX + XBAR_CYC;
    localparam int HOLD  = DIV_LAT - DEPTH;
    localparam int LANES = 2;

    iss_info_t               info;
    logic                    sb_haz, slot_haz, div_haz, fire;
    logic                    div_busy, div_inj;
    logic [RW-1:0]           div_inj_reg;
    logic [LANES-1:0]        put, tgt_busy, out_vld, set_en;
    logic [LANES-1:0][RW-1:0] put_reg, out_reg;
    logic [3:0]              chk_en;
    logic [3:0][RW-1:0]      chk_reg;
    logic                    dst0_nz, dst1_nz;

    wb_lat_table #(.XBAR_CYC(XBAR_CYC)) u_tab (
        .cls  (iss_cls),
        .info (info)
    );

    assign dst0_nz  = (iss_dst0 != '0);
    assign dst1_nz  = (iss_dst1 != '0);
    assign chk_en   = {info.pair, 3'b111};
    assign chk_reg  = {iss_dst1, iss_dst0, iss_src_b, iss_src_a};

    assign slot_haz  = !info.is_div && (tgt_busy[0] || (info.pair && tgt_busy[1]));
    assign div_haz   = info.is_div && div_busy;
    assign iss_stall = iss_valid && (sb_haz || slot_haz || div_haz);
    assign fire      = iss_valid && !iss_stall;

    assign set_en  = {fire && info.pair && dst1_nz, fire && dst0_nz};
    assign put     = {fire && info.pair && dst1_nz, fire && !info.is_div && dst0_nz};
    assign put_reg = {iss_dst1, iss_dst0};

    wb_scoreboard #(.NREG(NREG), .RW(RW), .NW(LANES), .NCHK(4)) u_sb (
        .clk     (clk),
        .rst     (rst),
        .set_en  (set_en),
        .set_reg (put_reg),
        .clr_en  (out_vld),
        .clr_reg (out_reg),
        .chk_en  (chk_en),
        .chk_reg (chk_reg),
        .hazard  (sb_haz)
    );

    wb_div_delay #(.HOLD(HOLD), .RW(RW)) u_div (
        .clk       (clk),
        .rst       (rst),
        .start     (fire && info.is_div),
        .start_reg (iss_dst0),
        .busy      (div_busy),
        .inj       (div_inj),
        .inj_reg   (div_inj_reg)
    );

    wb_slot_queue #(.DEPTH(DEPTH), .RW(RW), .LANES(LANES), .IW(SLOT_W)) u_q (
        .clk      (clk),
        .rst      (rst),
        .tgt      (info.slot),
        .put      (put),
        .put_reg  (put_reg),
        .inj      (div_inj),
        .inj_reg  (div_inj_reg),
        .tgt_busy (tgt_busy),
        .out_vld  (out_vld),
        .out_reg  (out_reg)
    );

    assign wb0_en  = out_vld[0];
    assign wb0_reg = out_reg[0];
    assign wb1_en  = out_vld[1];
    assign wb1_reg = out_reg[1];
endmodule

// File: rtl/wb_sched_chk.sv
module wb_sched_chk #(
    parameter int RW       = 6,
    parameter int XBAR_CYC = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          iss_valid,
    input logic [2:0]    iss_cls,
    input logic [RW-1:0] iss_src_a,
    input logic [RW-1:0] iss_dst0,
    input logic [RW-1:0] iss_dst1,
    input logic          iss_stall,
    input logic          wb0_en,
    input logic [RW-1:0] wb0_reg,
    input logic          wb1_en,
    input logic [RW-1:0] wb1_reg,
    input logic          div_busy
);
    // R9
    stall_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |-> !iss_stall);

    // R4
    r0_lane0_chk: assert property (@(posedge clk) disable iff (rst)
        wb0_en |-> wb0_reg != '0);

    // R4
    r0_lane1_chk: assert property (@(posedge clk) disable iff (rst)
        wb1_en |-> wb1_reg != '0);

    // R3
    raw_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_stall && iss_dst0 != '0) ##1
        (iss_valid && iss_src_a == $past(iss_dst0)) |-> iss_stall);

    // R7
    one_div_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_cls == 3'd4 && div_busy) |-> iss_stall);

    if (XBAR_CYC == 2) begin : g_lat
        // R2
        lat_logic_chk: assert property (@(posedge clk) disable iff (rst)
            (iss_valid && !iss_stall && iss_cls == 3'd0 && iss_dst0 != '0)
            |=> ##2 (wb0_en && wb0_reg == $past(iss_dst0, 3)));

        // R6
        pair_lat_chk: assert property (@(posedge clk) disable iff (rst)
            (iss_valid && !iss_stall && iss_cls == 3'd5 && iss_dst0 != '0 && iss_dst1 != '0)
            |=> ##3 (wb0_en && wb1_en && wb0_reg == $past(iss_dst0, 4)
                     && wb1_reg == $past(iss_dst1, 4)));
    end
endmodule

bind wb_sched wb_sched_chk #(.RW(RW), .XBAR_CYC(XBAR_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_cls   (iss_cls),
    .iss_src_a (iss_src_a),
    .iss_dst0  (iss_dst0),
    .iss_dst1  (iss_dst1),
    .iss_stall (iss_stall),
    .wb0_en    (wb0_en),
    .wb0_reg   (wb0_reg),
    .wb1_en    (wb1_en),
    .wb1_reg   (wb1_reg),
    .div_busy  (div_busy)
);

// File: tb/wb_sched_tb.sv
module wb_sched_tb;
    localparam int CLK_P   = 10;
    localparam int NREG    = 64;
    localparam int RW      = 6;
    localparam int XBAR    = 2;
    localparam int DIV_LAT = 14;
    localparam int DEPTH   = 8;
    localparam int HOLD    = DIV_LAT - DEPTH;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          iss_valid = 1'b0;
    logic [2:0]    iss_cls = '0;
    logic [RW-1:0] iss_src_a = '0, iss_src_b = '0, iss_dst0 = '0, iss_dst1 = '0;
    logic          iss_stall, wb0_en, wb1_en;
    logic [RW-1:0] wb0_reg, wb1_reg;

    wb_sched #(.NREG(NREG), .XBAR_CYC(XBAR), .DIV_LAT(DIV_LAT)) u_dut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_cls(iss_cls),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst0(iss_dst0),
        .iss_dst1(iss_dst1), .iss_stall(iss_stall), .wb0_en(wb0_en),
        .wb0_reg(wb0_reg), .wb1_en(wb1_en), .wb1_reg(wb1_reg)
    );

    always #(CLK_P/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc = cyc + 1;

    typedef struct {
        int    at;
        int    lane;
        int    rg;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    function automatic int slot_of(int cls);
        case (cls)
            2, 5:    return 2 + XBAR;
            3:       return 6 + XBAR;
            4:       return DIV_LAT;
            default: return 1 + XBAR;
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Driver: called at a falling edge; returns the accepted cycle.
    task automatic issue(int cls, int a, int b, int d0, int d1, string req, output int c);
        int s;
        iss_valid = 1'b1;
        iss_cls   = cls[2:0];
        iss_src_a = a[RW-1:0];
        iss_src_b = b[RW-1:0];
        iss_dst0  = d0[RW-1:0];
        iss_dst1  = d1[RW-1:0];
        #1;
        while (iss_stall) begin
            @(negedge clk);
            #1;
        end
        c = cyc;
        s = slot_of(cls);
        if (d0 != 0) exp_q.push_back('{c + s, 0, d0, req});
        if (cls == 5 && d1 != 0) exp_q.push_back('{c + s, 1, d1, req});
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    // Monitor: pops expected writes as the lanes produce them.
    initial begin
        logic          en;
        logic [RW-1:0] rg;
        int            idx;
        forever begin
            @(negedge clk);
            if (!rst) begin
                for (int l = 0; l < 2; l++) begin
                    en = (l == 0) ? wb0_en : wb1_en;
                    rg = (l == 0) ? wb0_reg : wb1_reg;
                    if (en) begin
                        idx = -1;
                        for (int i = 0; i < exp_q.size(); i++)
                            if (exp_q[i].at == cyc && exp_q[i].lane == l && exp_q[i].rg == int'(rg))
                                idx = i;
                        checks++;
                        if (idx < 0) begin
                            fails++;
                            $display("FAIL R9 unexpected write lane %0d cycle %0d: actual=r%0d expected=none",
                                     l, cyc, rg);
                        end else begin
                            exp_q.delete(idx);
                        end
                    end
                end
                for (int i = exp_q.size() - 1; i >= 0; i--) begin
                    if (exp_q[i].at < cyc) begin
                        checks++;
                        fails++;
                        $display("FAIL %s missing write lane %0d: actual=none expected=r%0d at cycle %0d",
                                 exp_q[i].req, exp_q[i].lane, exp_q[i].rg, exp_q[i].at);
                        exp_q.delete(i);
                    end
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int c0, c1, c2, c3, cm, cp, cd, cd2;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: idle outputs and no stall on a free request
        chk(wb0_en == 1'b0, "R1", "wb0_en after reset", wb0_en, 0);
        chk(wb1_en == 1'b0, "R1", "wb1_en after reset", wb1_en, 0);
        iss_valid = 1'b1; iss_src_a = 6'd1; iss_src_b = 6'd2; iss_dst0 = 6'd3;
        #1;
        chk(iss_stall == 1'b0, "R1", "stall with all ready", iss_stall, 0);
        iss_valid = 1'b0;
        @(negedge clk);

        // R2: each class back to back, distinct write-back cycles
        issue(0, 1, 2, 10, 0, "R2", c0);
        issue(1, 1, 2, 11, 0, "R2", c1);
        issue(2, 1, 2, 12, 0, "R2", c2);
        issue(3, 1, 2, 13, 0, "R2", c3);
        chk(c1 == c0 + 1, "R2", "byte add issue cycle", c1, c0 + 1);
        chk(c2 == c0 + 2, "R2", "add issue cycle", c2, c0 + 2);
        chk(c3 == c0 + 3, "R2", "mul issue cycle", c3, c0 + 3);
        repeat (12) @(negedge clk);

        // R3: read after a pending multiply
        issue(3, 0, 0, 20, 0, "R3", c0);
        issue(0, 20, 0, 21, 0, "R3", c1);
        chk(c1 == c0 + 9, "R3", "src_a waits for write", c1, c0 + 9);
        // R3: source B and destination overlap
        issue(2, 0, 0, 22, 0, "R3", c0);
        issue(0, 0, 22, 23, 0, "R3", c1);
        chk(c1 == c0 + 5, "R3", "src_b waits for write", c1, c0 + 5);
        issue(1, 0, 0, 23, 0, "R3", c2);
        chk(c2 == c1 + 4, "R3", "dst waits for write", c2, c1 + 4);
        repeat (10) @(negedge clk);

        // R4: register 0 is never pending nor written
        issue(3, 0, 0, 0, 0, "R4", c0);
        issue(0, 0, 0, 24, 0, "R4", c1);
        chk(c1 == c0 + 1, "R4", "r0 source no stall", c1, c0 + 1);
        repeat (12) @(negedge clk);

        // R5: lane-0 slot collision
        issue(2, 0, 0, 30, 0, "R5", c0);
        issue(0, 0, 0, 31, 0, "R5", c1);
        chk(c1 == c0 + 2, "R5", "logic after add", c1, c0 + 2);
        repeat (8) @(negedge clk);

        // R6: paired write and collision with an earlier multiply
        issue(5, 0, 0, 40, 41, "R6", c0);
        repeat (6) @(negedge clk);
        issue(3, 0, 0, 42, 0, "R6", cm);
        while (cyc < cm + 4) @(negedge clk);
        issue(5, 0, 0, 43, 44, "R6", cp);
        chk(cp == cm + 5, "R6", "pair blocked by booked slot", cp, cm + 5);
        repeat (10) @(negedge clk);

        // R7: one divide at a time
        issue(4, 0, 0, 50, 0, "R7", cd);
        issue(4, 0, 0, 51, 0, "R7", cd2);
        chk(cd2 == cd + HOLD + 1, "R7", "second divide issue", cd2, cd + HOLD + 1);
        repeat (30) @(negedge clk);

        // R8: multiply blocked by the divide entering the top slot
        issue(4, 0, 0, 52, 0, "R8", cd);
        while (cyc < cd + HOLD) @(negedge clk);
        issue(3, 0, 0, 53, 0, "R8", cm);
        chk(cm == cd + HOLD + 1, "R8", "mul vs divide injection", cm, cd + HOLD + 1);
        repeat (20) @(negedge clk);

        // R9: no stall without a request, even with a pending register
        issue(3, 0, 0, 60, 0, "R9", c0);
        iss_src_a = 6'd60;
        #1;
        chk(iss_stall == 1'b0, "R9", "stall without valid", iss_stall, 0);
        iss_valid = 1'b1;
        #1;
        chk(iss_stall == 1'b1, "R9", "stall with valid", iss_stall, 1);
        iss_valid = 1'b0;
        repeat (15) @(negedge clk);

        chk(exp_q.size() == 0, "R2", "outstanding writes", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule